// File: doc/BRIEF.md
# Initial Bad Block Table Builder

This engine runs once on a freshly delivered small-page NAND device, before any erase or program, to find the blocks the manufacturer flagged as unusable. It walks every block from the lowest address upward. For each block it reads the factory marker byte at spare column 517 from the first page and then from the second page. A marker other than FFh in either page means the block is recorded as bad. It does not drive the flash bus itself. Each marker fetch goes out as a request on a read port (page row plus column), and a NAND host sequencer returns the byte with an acknowledge.

The results go into a one-bit-per-block bitmap that system software or a remapping unit can read after the scan. The engine also gives the total number of bad blocks, a done flag, and a fault flag. The fault flag is raised when the valid-block count falls below the guaranteed minimum, either over the whole device or in either half of the address space. Block 0 is always reported as good. A new start pulse clears the previous table and begins a fresh scan.

Top module: `bbt_scan_top`

## Requirements
- R1: After synchronous active-low reset, `busy`, `done`, `rd_req`, `fault` and `tbl_bad` are 0 and `bad_count` is 0.
- R2: Requests cover blocks 0 to NUM_BLOCKS-1 in ascending order, page 0 before page 1. `rd_row` equals block×PAGES_PER_BLOCK + page and `rd_col` equals MARK_COL (517). `rd_req` and `rd_row` stay constant until the cycle in which `rd_ack` is sampled high. The byte is taken from `rd_data` in that same cycle.
- R3: A block is bad when the marker of page 0 or of page 1 differs from 8'hFF. A block whose two markers both equal 8'hFF is good.
- R4: Block 0 is reported good whatever its marker values, and it is never counted in `bad_count`.
- R5: In the cycle after the edge that takes the final acknowledge, `done` is 1, `busy` is 0 and `bad_count` holds the number of bad blocks. These values are held until the next accepted start.
- R6: When `done` is 1, `fault` is 1 if NUM_BLOCKS minus `bad_count` is less than MIN_VALID_TOTAL.
- R7: When `done` is 1, `fault` is also 1 if the valid blocks in the lower half or in the upper half number fewer than MIN_VALID_HALF. Otherwise `fault` is 0, and `fault` is always 0 while `done` is 0.
- R8: `tbl_bad` shows, one cycle after `tbl_addr` is applied, the bitmap entry for that block (1 = bad). It reads 0 on any cycle that follows a cycle with `busy` high.
- R9: A start pulse while `busy` is 1 is ignored. The scan continues in sequence and its results are unchanged.
- R10: A start pulse while not busy clears the bitmap and the counts, drops `done`, and raises `busy` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new scan (single-cycle pulse) |
| rd_req | output | 1 | Marker read request to the host sequencer |
| rd_row | output | ROW_W | Page row address of the request |
| rd_col | output | COL_W | Column of the marker byte |
| rd_ack | input | 1 | Sequencer returns `rd_data` for the pending request |
| rd_data | input | 8 | Marker byte |
| tbl_addr | input | BLK_W | Block number to look up in the table |
| tbl_bad | output | 1 | Table entry for `tbl_addr`, one cycle later |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete, results valid |
| bad_count | output | CNT_W | Number of bad blocks found |
| fault | output | 1 | Valid-block minimum violated |

## Verification
The bench drives inputs and samples outputs on falling edges. Each result is due at a fixed number of rising edges after the input that causes it. `busy` rises one edge after a start pulse. The next request address appears one edge after an acknowledge. `done`, `bad_count` and `fault` settle one edge after the last acknowledge. A table lookup returns one edge after the address is applied. The acknowledging model checks the done flag at the falling edge that follows the final acknowledge, and it checks each row as it serves the request. After each scan the table is swept entry by entry, one lookup per cycle. Expected values come from the marker pattern the bench loaded, so the checks never wait an open-ended time for a result.

// File: rtl/bbt_pkg.sv
// Shared types for the bad block table builder.
package bbt_pkg;
    // Scan controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;

    // Marker value of a good block
    localparam logic [7:0] GOOD_MARK = 8'hFF;
endpackage

// File: rtl/bbt_addr_gen.sv
// Block/page walker: steps through page 0 and page 1 of each block in
// ascending block order and forms the page row address.
// Assumes PAGES_PER_BLOCK is a power of two, at least 2.
module bbt_addr_gen #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 32,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [BLK_W-1:0] blk,
    output logic             pg,
    output logic [ROW_W-1:0] row,
    output logic             last
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    logic [BLK_W-1:0] blk_q;
    logic             pg_q;

    // Advance page index, then block index, on each accepted read
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            blk_q <= '0;
            pg_q  <= 1'b0;
        end else if (step) begin
            pg_q <= ~pg_q;
            if (pg_q) blk_q <= blk_q + BLK_W'(1);
        end
    end

    // Row = block * pages + page index
    always_comb begin
        blk  = blk_q;
        pg   = pg_q;
        row  = {blk_q, (PG_W)'(pg_q)};
        last = pg_q && (blk_q == LAST_BLK);
    end
endmodule

// File: rtl/bbt_table.sv
// One-bit-per-block table of bad blocks with a registered read port.
// Assumes the clear and write requests never coincide.
module bbt_table #(
    parameter int NUM_BLOCKS = 2048,
    localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_addr,
    input  logic             wr_bad,
    input  logic [BLK_W-1:0] rd_addr,
    input  logic             rd_block,
    output logic             rd_bad
);
    logic [NUM_BLOCKS-1:0] map_q;
    logic                  rd_q;

    // Store the verdict of each finished block; wiped on a new scan
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            map_q <= '0;
        end else if (wr_en) begin
            map_q[wr_addr] <= wr_bad;
        end
    end

    // Registered lookup, forced to 0 while the scan owns the table
    always_ff @(posedge clk) begin
        if (!rst_n || rd_block) rd_q <= 1'b0;
        else                    rd_q <= map_q[rd_addr];
    end

    assign rd_bad = rd_q;
endmodule

// File: rtl/bbt_tally.sv
// Per-half bad block counters and the valid-block minimum comparison.
// Assumes NUM_BLOCKS is even and the minimums do not exceed the sizes.
module bbt_tally #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int MIN_VALID_TOTAL = 2013,
    parameter int MIN_VALID_HALF  = 1004,
    localparam int HALF   = NUM_BLOCKS / 2,
    localparam int HCNT_W = $clog2(HALF + 1),
    localparam int CNT_W  = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic             add_upper,
    output logic [CNT_W-1:0] bad_total,
    output logic             short_valid
);
    localparam logic [CNT_W-1:0]  MAX_BAD_TOT  = CNT_W'(NUM_BLOCKS - MIN_VALID_TOTAL);
    localparam logic [HCNT_W-1:0] MAX_BAD_HALF = HCNT_W'(HALF - MIN_VALID_HALF);

    logic [HCNT_W-1:0] bad_lo_q;
    logic [HCNT_W-1:0] bad_hi_q;

    // Count bad blocks separately for each half of the address space
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bad_lo_q <= '0;
            bad_hi_q <= '0;
        end else if (add_en) begin
            if (add_upper) bad_hi_q <= bad_hi_q + HCNT_W'(1);
            else           bad_lo_q <= bad_lo_q + HCNT_W'(1);
        end
    end

    // Total and minimum checks
    always_comb begin
        bad_total   = CNT_W'(bad_lo_q) + CNT_W'(bad_hi_q);
        short_valid = (bad_total > MAX_BAD_TOT) ||
                      (bad_lo_q > MAX_BAD_HALF) ||
                      (bad_hi_q > MAX_BAD_HALF);
    end
endmodule

// File: rtl/bbt_scan_top.sv
// Initial bad block table builder. Requests the marker byte of pages 0
// and 1 of each block through a request/acknowledge port, marks a block
// bad if either byte is not FFh (block 0 excepted), and publishes a
// bitmap, a bad count, a done flag and a minimum-valid fault flag.
// Assumes rd_data is valid in the cycle rd_ack is high while rd_req is high.
module bbt_scan_top #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int MIN_VALID_TOTAL = 2013,
    parameter int MIN_VALID_HALF  = 1004,
    parameter int COL_W           = 10,
    parameter int MARK_COL        = 517,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_req,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    input  logic             rd_ack,
    input  logic [7:0]       rd_data,
    input  logic [BLK_W-1:0] tbl_addr,
    output logic             tbl_bad,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bad_count,
    output logic             fault
);
    import bbt_pkg::*;

    scan_state_t      state_q;
    logic             start_ok;
    logic             take;
    logic             blk_bad;
    logic             wr_en;
    logic             pg0_bad_q;
    logic [BLK_W-1:0] blk;
    logic             pg;
    logic             last;
    logic             short_valid;

    assign start_ok = start && (state_q != ST_SCAN);
    assign take     = (state_q == ST_SCAN) && rd_ack;
    assign wr_en    = take && pg;
    assign blk_bad  = (pg0_bad_q || (rd_data != GOOD_MARK)) && (blk != '0);

    // Scan sequencing: idle -> scan -> done, restart only when not scanning
    always_ff @(posedge clk) begin
        if (!rst_n)                state_q <= ST_IDLE;
        else if (start_ok)         state_q <= ST_SCAN;
        else if (take && last)     state_q <= ST_DONE;
    end

    // Hold the page 0 verdict until the page 1 byte arrives
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok)    pg0_bad_q <= 1'b0;
        else if (take && !pg)      pg0_bad_q <= (rd_data != GOOD_MARK);
    end

    bbt_addr_gen #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
    ) addr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_ok),
        .step  (take),
        .blk   (blk),
        .pg    (pg),
        .row   (rd_row),
        .last  (last)
    );

    bbt_table #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_ok),
        .wr_en    (wr_en),
        .wr_addr  (blk),
        .wr_bad   (blk_bad),
        .rd_addr  (tbl_addr),
        .rd_block (state_q == ST_SCAN),
        .rd_bad   (tbl_bad)
    );

    bbt_tally #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .MIN_VALID_TOTAL (MIN_VALID_TOTAL),
        .MIN_VALID_HALF  (MIN_VALID_HALF)
    ) tally_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start_ok),
        .add_en      (wr_en && blk_bad),
        .add_upper   (blk[BLK_W-1]),
        .bad_total   (bad_count),
        .short_valid (short_valid)
    );

    // Output decode
    always_comb begin
        busy   = (state_q == ST_SCAN);
        done   = (state_q == ST_DONE);
        rd_req = busy;
        rd_col = COL_W'(MARK_COL);
        fault  = done && short_valid;
    end
endmodule

// File: rtl/bbt_scan_chk.sv
// Protocol and result checks for bbt_scan_top, attached by bind.
module bbt_scan_chk #(
    parameter int NUM_BLOCKS = 2048,
    parameter int ROW_W      = 16,
    parameter int CNT_W      = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_req,
    input logic [ROW_W-1:0] rd_row,
    input logic             rd_ack,
    input logic             tbl_bad,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] bad_count,
    input logic             fault
);
    // R2: request and address hold until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_row));

    // R2: page 0 is followed by page 1 of the same block
    a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && !rd_row[0] |=> rd_row == $past(rd_row) + ROW_W'(1));

    // R1: no request outside a scan
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);

    // R5: busy and done never overlap
    a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4: block 0 never counted, so count stays below the block total
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bad_count <= CNT_W'(NUM_BLOCKS - 1));

    // R7: fault only with done
    a_r7_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    // R8: table reads blocked during a scan
    a_r8_tbl_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !tbl_bad);

    // R9: start during a scan does not restart it
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !rd_ack |=> busy && $stable(rd_row));
endmodule

bind bbt_scan_top bbt_scan_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .ROW_W      (ROW_W),
    .CNT_W      (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_req    (rd_req),
    .rd_row    (rd_row),
    .rd_ack    (rd_ack),
    .tbl_bad   (tbl_bad),
    .busy      (busy),
    .done      (done),
    .bad_count (bad_count),
    .fault     (fault)
);

// File: tb/bbt_scan_top_tb_top.sv
module bbt_scan_top_tb_top;
    localparam int N     = 16;
    localparam int PG    = 4;
    localparam int MIN_T = 13;
    localparam int MIN_H = 6;
    localparam int BLK_W = 4;
    localparam int ROW_W = 6;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rd_req;
    logic [ROW_W-1:0] rd_row;
    logic [9:0]       rd_col;
    logic             rd_ack = 1'b0;
    logic [7:0]       rd_data = 8'h00;
    logic [BLK_W-1:0] tbl_addr = '0;
    logic             tbl_bad;
    logic             busy;
    logic             done;
    logic [CNT_W-1:0] bad_count;
    logic             fault;

    int n_chk = 0;
    int n_fail = 0;
    int seq = 0;
    int row_err = 0;
    int wait_cnt = 0;
    logic [7:0] mark0 [N];
    logic [7:0] mark1 [N];

    always #5 clk = ~clk;

    bbt_scan_top #(
        .NUM_BLOCKS(N), .PAGES_PER_BLOCK(PG),
        .MIN_VALID_TOTAL(MIN_T), .MIN_VALID_HALF(MIN_H)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .tbl_addr(tbl_addr), .tbl_bad(tbl_bad),
        .busy(busy), .done(done), .bad_count(bad_count), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sequencer model: variable latency, checks each request address
    initial begin
        forever begin
            @(negedge clk);
            if (rd_ack) begin
                rd_ack = 1'b0;
                if (seq == 2 * N)
                    chk(done && !busy, "R5 done after final ack", int'(done), 1);
            end else if (rd_req) begin
                if (wait_cnt < (seq % 3)) begin
                    wait_cnt++;
                end else begin
                    if (seq >= 2 * N || int'(rd_row) != (seq / 2) * PG + (seq % 2)
                        || rd_col != 10'd517) row_err++;
                    rd_data = (seq >= 2 * N) ? 8'hFF :
                              ((seq % 2) != 0) ? mark1[seq / 2] : mark0[seq / 2];
                    rd_ack = 1'b1;
                    seq++;
                    wait_cnt = 0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic load(input int b0, input int b1, input int b2, input int b3);
        for (int b = 0; b < N; b++) begin
            mark0[b] = 8'hFF;
            mark1[b] = 8'hFF;
        end
        if (b0 >= 0) mark0[b0] = 8'h00;
        if (b1 >= 0) mark1[b1] = 8'hFE;
        if (b2 >= 0) begin mark0[b2] = 8'h7F; mark1[b2] = 8'h7F; end
        if (b3 >= 0) mark0[b3] = 8'hF0;
    endtask

    task automatic run_scan(input bit inject, input string tag);
        int exp_bad;
        int lo;
        int hi;
        bit exp_fault;
        bit bad_b;
        seq = 0;
        row_err = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && !done, "R10 busy after start", int'(busy), 1);
        if (inject) begin
            fork
                begin
                    wait (seq == 10);
                    @(negedge clk) tbl_addr = 4'd2;
                    @(negedge clk);
                    chk(tbl_bad == 1'b0, "R8 lookup blocked while busy", int'(tbl_bad), 0);
                    wait (seq == 14);
                    @(negedge clk) start = 1'b1;
                    @(negedge clk) start = 1'b0;
                end
            join_none
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        lo = 0;
        hi = 0;
        for (int b = 1; b < N; b++) begin
            if (mark0[b] != 8'hFF || mark1[b] != 8'hFF) begin
                if (b < N / 2) lo++; else hi++;
            end
        end
        exp_bad = lo + hi;
        exp_fault = (N - exp_bad < MIN_T) || (N / 2 - lo < MIN_H) || (N / 2 - hi < MIN_H);
        chk(row_err == 0 && seq == 2 * N, {"R2 request order ", tag}, row_err, 0);
        chk(int'(bad_count) == exp_bad, {"R5 bad_count ", tag}, int'(bad_count), exp_bad);
        chk(fault == exp_fault, {"R6 R7 fault ", tag}, int'(fault), int'(exp_fault));
        for (int b = 0; b < N; b++) begin
            tbl_addr = BLK_W'(b);
            @(negedge clk);
            bad_b = (b != 0) && (mark0[b] != 8'hFF || mark1[b] != 8'hFF);
            chk(tbl_bad == bad_b, {"R3 R4 table entry ", tag}, int'(tbl_bad), int'(bad_b));
        end
    endtask

    initial begin
        load(-1, -1, -1, -1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_req, "R1 control idle", int'(busy), 0);
        chk(bad_count == 0 && !fault, "R1 counts clear", int'(bad_count), 0);
        chk(!tbl_bad, "R1 table read clear", int'(tbl_bad), 0);

        // all good
        run_scan(1'b0, "all good");
        // block 0 marked, bad 2 (page0), 5 (page1), 9 (both); no fault
        load(2, 5, 9, 0);
        run_scan(1'b1, "mixed R9 start mid-scan");
        chk(done && !busy, "R9 scan not restarted", int'(done), 1);
        // upper half short: 9, 11, 14 -> R7 fault
        load(-1, 11, 9, 14);
        run_scan(1'b0, "R7 half minimum");
        // total short: 2, 5, 9, 14 -> R6 fault
        load(2, 5, 9, 14);
        run_scan(1'b0, "R6 total minimum");
        // fresh start clears previous table
        load(-1, -1, -1, -1);
        run_scan(1'b0, "R10 rescan clears");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule